// File: doc/BRIEF.md
# Memory type range register file

This block holds the memory-type range registers and the page-attribute register of one processor context. Software reaches them through a simple port that uses model-specific register numbers. The port has one write channel and one read channel. Before a write is stored, the block checks it against that register's own rule. The rules cover the legal one-byte type codes, the reserved bit fields and a configurable physical address width. An illegal write is refused and the block reports a fault. Some reserved-bit violations also report a general-protection indication. An accepted write updates the register.

Reads return the stored value, or the capability word for the one read-only register number. For variable ranges, the read value is clipped to the physical address width. The stored variable-range state is also driven out on side ports for a separate lookup block. The stored enable flags and the default type are driven out in the same way. On those side ports a mask appears with every bit at and above the address width forced to one.

Writes and reads each take one clock. The response flags and the read data are registered. When a read and a write arrive in the same cycle, the read returns the value held before that write.

Top module: `memtype_range_regs`

## Requirements
- R1: After reset every stored register is zero. A read of any stored register number returns 0. wr_ack, wr_fault, wr_gp, rd_valid, var_valid_o, glob_en_o, fix_en_o and def_type_o are all 0.
- R2: One cycle after wr_en, wr_ack is high for exactly one cycle. wr_fault is 1 in that cycle when the write was refused. wr_gp is 1 only together with wr_fault.
- R3: A write to a number that names no writable register is refused with wr_fault=1 and wr_gp=0, and no stored state changes. The capability number 0x0FE counts as such a number, and so does any variable-range number at or beyond 0x200+2*NUM_VAR. A refused write of any kind leaves all stored state unchanged.
- R4: Variable range i has its base at number 0x200+2i. A base write is refused with wr_gp=1 if any of bits 11:8, or any bit at or above PA_W, is set. Otherwise it is refused with wr_gp=0 if bits 7:0 are not one of the legal type codes 0, 1, 4, 5 or 6.
- R5: Variable range i has its mask at number 0x201+2i. A mask write with any of bits 10:0 set, or any bit at or above PA_W set, is refused with wr_gp=1.
- R6: An accepted mask is stored with bits 63:PA_W forced to one, and var_mask_o shows it that way. Reads of a base or a mask return only bits PA_W-1:0.
- R7: var_valid_o[i] equals bit 11 of the stored mask of range i.
- R8: The fixed-range registers are at 0x250, 0x258, 0x259 and 0x268 to 0x26F. Each holds eight one-byte types. A write is accepted only if every byte is 0, 1, 4, 5 or 6.
- R9: The default-type register is at 0x2FF. A write is refused if any bit outside 0xCFF is set, or if bits 7:0 are not a legal type code. glob_en_o is bit 11, fix_en_o is bit 10 and def_type_o is bits 7:0 of the stored value.
- R10: The page-attribute register is at 0x277. A write is accepted only if each of its eight bytes is 0, 1, 4, 5, 6 or 7.
- R11: One cycle after rd_en, rd_valid is high for one cycle with rd_data. A read of 0x0FE returns 0x500 OR NUM_VAR. An unknown number gives rd_fault=1 and rd_data=0. A read in the same cycle as a write to the same register returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request this cycle |
| wr_num | input | 32 | Register number of the write |
| wr_data | input | 64 | Write value |
| rd_en | input | 1 | Read request this cycle |
| rd_num | input | 32 | Register number of the read |
| wr_ack | output | 1 | Write response strobe |
| wr_fault | output | 1 | Write was refused |
| wr_gp | output | 1 | Refusal carries a general-protection indication |
| rd_valid | output | 1 | Read response strobe |
| rd_fault | output | 1 | Read of an unknown number |
| rd_data | output | 64 | Read value |
| var_base_o | output | 64*NUM_VAR | Stored variable bases, range i at bits 64i+63:64i |
| var_mask_o | output | 64*NUM_VAR | Stored variable masks with high ones, same layout |
| var_valid_o | output | NUM_VAR | Per-range valid flags |
| fixed_o | output | 704 | Stored fixed-range registers, entry k at bits 64k+63:64k |
| glob_en_o | output | 1 | Global enable flag |
| fix_en_o | output | 1 | Fixed-range enable flag |
| def_type_o | output | 8 | Default memory type |

## Verification
A validation fault that accepts too much shows up on the write cycle itself: wr_fault stays low, and the next read or side-port sample returns the illegal value. A validation fault that refuses too much keeps the old value readable. A wrong register-number decode sends data to a neighbouring register, so a directed read of both neighbours exposes it one cycle after the read request. A missing mask extension or a missing read clip shows at once on var_mask_o or rd_data, because the bench checks both views of every mask it writes.

// File: rtl/memtype_pkg.sv
package memtype_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_VBASE,
        RK_VMASK,
        RK_FIXED,
        RK_DEFTYPE,
        RK_PAT,
        RK_CAP
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] idx;
    } reg_sel_t;

    localparam int unsigned FIXED_REGS  = 11;
    localparam int unsigned WORD_W      = 64;
    localparam logic [31:0] NUM_VAR0    = 32'h0000_0200;
    localparam logic [31:0] NUM_FIX64   = 32'h0000_0250;
    localparam logic [31:0] NUM_FIX16   = 32'h0000_0258;
    localparam logic [31:0] NUM_FIX4    = 32'h0000_0268;
    localparam logic [31:0] NUM_DEFTYPE = 32'h0000_02FF;
    localparam logic [31:0] NUM_PAT     = 32'h0000_0277;
    localparam logic [31:0] NUM_CAP     = 32'h0000_00FE;

    // Map a register number to its kind and slot. NUM_VAR must be 1..16.
    function automatic reg_sel_t decode_num(logic [31:0] num, int unsigned nvar);
        reg_sel_t   s;
        logic [31:0] off;
        s.kind = RK_NONE;
        s.idx  = 4'd0;
        off    = num - NUM_VAR0;
        if (num >= NUM_VAR0 && off < 32'(2 * nvar)) begin
            s.kind = off[0] ? RK_VMASK : RK_VBASE;
            s.idx  = off[4:1];
        end else if (num == NUM_FIX64) begin
            s.kind = RK_FIXED;
            s.idx  = 4'd0;
        end else if (num[31:1] == NUM_FIX16[31:1]) begin
            s.kind = RK_FIXED;
            s.idx  = 4'd1 + {3'd0, num[0]};
        end else if (num[31:3] == NUM_FIX4[31:3]) begin
            s.kind = RK_FIXED;
            s.idx  = 4'd3 + {1'b0, num[2:0]};
        end else if (num == NUM_DEFTYPE) begin
            s.kind = RK_DEFTYPE;
        end else if (num == NUM_PAT) begin
            s.kind = RK_PAT;
        end else if (num == NUM_CAP) begin
            s.kind = RK_CAP;
        end
        return s;
    endfunction

    function automatic logic legal_range_type(logic [7:0] t);
        return (t[7:3] == 5'd0) && (t[2:0] inside {3'd0, 3'd1, 3'd4, 3'd5, 3'd6});
    endfunction

    function automatic logic legal_pat_type(logic [7:0] t);
        return (t[7:3] == 5'd0) && (t[2:0] != 3'd2) && (t[2:0] != 3'd3);
    endfunction

endpackage

// File: rtl/mtr_wr_check.sv
module mtr_wr_check
    import memtype_pkg::*;
#(
    parameter int unsigned PA_W = 36
) (
    input  reg_kind_e   kind,
    input  logic [63:0] wdata,
    output logic        ok,
    output logic        gp
);
    localparam logic [63:0] HI_MASK    = ~((64'd1 << PA_W) - 64'd1);
    localparam logic [63:0] BASE_RSVD  = HI_MASK | 64'h0000_0000_0000_0F00;
    localparam logic [63:0] MASK_RSVD  = HI_MASK | 64'h0000_0000_0000_07FF;
    localparam logic [63:0] DEF_LEGAL  = 64'h0000_0000_0000_0CFF;

    logic [7:0] byte_range_ok;
    logic [7:0] byte_pat_ok;

    for (genvar b = 0; b < 8; b++) begin : g_byte
        assign byte_range_ok[b] = legal_range_type(wdata[8*b +: 8]);
        assign byte_pat_ok[b]   = legal_pat_type(wdata[8*b +: 8]);
    end

    logic base_rsvd_hit;
    logic mask_rsvd_hit;
    logic def_rsvd_hit;

    assign base_rsvd_hit = |(wdata & BASE_RSVD);
    assign mask_rsvd_hit = |(wdata & MASK_RSVD);
    assign def_rsvd_hit  = |(wdata & ~DEF_LEGAL);

    always_comb begin
        ok = 1'b0;
        gp = 1'b0;
        unique case (kind)
            RK_VBASE: begin
                gp = base_rsvd_hit;
                ok = !base_rsvd_hit && byte_range_ok[0];
            end
            RK_VMASK: begin
                gp = mask_rsvd_hit;
                ok = !mask_rsvd_hit;
            end
            RK_FIXED:   ok = &byte_range_ok;
            RK_DEFTYPE: ok = !def_rsvd_hit && byte_range_ok[0];
            RK_PAT:     ok = &byte_pat_ok;
            default: begin
                ok = 1'b0;
                gp = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mtr_rd_fmt.sv
module mtr_rd_fmt
    import memtype_pkg::*;
#(
    parameter int unsigned NUM_VAR = 8,
    parameter int unsigned PA_W    = 36
) (
    input  reg_sel_t                             sel,
    input  logic [NUM_VAR-1:0][63:0]             vbase,
    input  logic [NUM_VAR-1:0][63:0]             vmask,
    input  logic [FIXED_REGS-1:0][63:0]          fixed,
    input  logic [63:0]                          deftype,
    input  logic [63:0]                          pat,
    output logic [63:0]                          data,
    output logic                                 hit
);
    localparam int unsigned VI_W    = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;
    localparam logic [63:0] LO_MASK = (64'd1 << PA_W) - 64'd1;
    localparam logic [63:0] CAP_WORD = 64'h500 | 64'(NUM_VAR);

    logic [VI_W-1:0] vi;
    assign vi = sel.idx[VI_W-1:0];

    always_comb begin
        data = 64'd0;
        hit  = 1'b1;
        unique case (sel.kind)
            RK_VBASE:   data = vbase[vi] & LO_MASK;
            RK_VMASK:   data = vmask[vi] & LO_MASK;
            RK_FIXED:   data = fixed[sel.idx];
            RK_DEFTYPE: data = deftype;
            RK_PAT:     data = pat;
            RK_CAP:     data = CAP_WORD;
            default: begin
                data = 64'd0;
                hit  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/memtype_range_regs.sv
module memtype_range_regs
    import memtype_pkg::*;
#(
    parameter int unsigned NUM_VAR = 8,
    parameter int unsigned PA_W    = 36
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [31:0]                 wr_num,
    input  logic [63:0]                 wr_data,
    input  logic                        rd_en,
    input  logic [31:0]                 rd_num,
    output logic                        wr_ack,
    output logic                        wr_fault,
    output logic                        wr_gp,
    output logic                        rd_valid,
    output logic                        rd_fault,
    output logic [63:0]                 rd_data,
    output logic [64*NUM_VAR-1:0]       var_base_o,
    output logic [64*NUM_VAR-1:0]       var_mask_o,
    output logic [NUM_VAR-1:0]          var_valid_o,
    output logic [64*FIXED_REGS-1:0]    fixed_o,
    output logic                        glob_en_o,
    output logic                        fix_en_o,
    output logic [7:0]                  def_type_o
);
    localparam int unsigned VI_W    = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;
    localparam logic [63:0] HI_MASK = ~((64'd1 << PA_W) - 64'd1);
    localparam int unsigned STORE_W = 64 * (2 * NUM_VAR + FIXED_REGS + 2);

    typedef struct packed {
        logic [NUM_VAR-1:0][63:0]    vbase;
        logic [NUM_VAR-1:0][63:0]    vmask;
        logic [FIXED_REGS-1:0][63:0] fixed;
        logic [63:0]                 deftype;
        logic [63:0]                 pat;
        logic                        wr_ack;
        logic                        wr_fault;
        logic                        wr_gp;
        logic                        rd_valid;
        logic                        rd_fault;
        logic [63:0]                 rd_data;
    } regs_t;

    regs_t state_d, state_q;

    reg_sel_t    wsel, rsel;
    logic        wr_ok, wr_gp_c;
    logic [63:0] rd_val;
    logic        rd_hit;

    assign wsel = decode_num(wr_num, NUM_VAR);
    assign rsel = decode_num(rd_num, NUM_VAR);

    mtr_wr_check #(.PA_W(PA_W)) u_wr_check (
        .kind  (wsel.kind),
        .wdata (wr_data),
        .ok    (wr_ok),
        .gp    (wr_gp_c)
    );

    mtr_rd_fmt #(.NUM_VAR(NUM_VAR), .PA_W(PA_W)) u_rd_fmt (
        .sel     (rsel),
        .vbase   (state_q.vbase),
        .vmask   (state_q.vmask),
        .fixed   (state_q.fixed),
        .deftype (state_q.deftype),
        .pat     (state_q.pat),
        .data    (rd_val),
        .hit     (rd_hit)
    );

    logic [VI_W-1:0] wvi;
    assign wvi = wsel.idx[VI_W-1:0];

    always_comb begin
        state_d          = state_q;
        state_d.wr_ack   = wr_en;
        state_d.wr_fault = 1'b0;
        state_d.wr_gp    = 1'b0;
        state_d.rd_valid = rd_en;
        state_d.rd_fault = 1'b0;
        state_d.rd_data  = 64'd0;
        if (rd_en) begin
            state_d.rd_fault = !rd_hit;
            state_d.rd_data  = rd_hit ? rd_val : 64'd0;
        end
        if (wr_en) begin
            state_d.wr_fault = !wr_ok;
            state_d.wr_gp    = wr_gp_c;
            if (wr_ok) begin
                unique case (wsel.kind)
                    RK_VBASE:   state_d.vbase[wvi]       = wr_data;
                    RK_VMASK:   state_d.vmask[wvi]       = wr_data | HI_MASK;
                    RK_FIXED:   state_d.fixed[wsel.idx]  = wr_data;
                    RK_DEFTYPE: state_d.deftype          = wr_data;
                    RK_PAT:     state_d.pat              = wr_data;
                    default:    state_d.pat              = state_q.pat;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign wr_ack     = state_q.wr_ack;
    assign wr_fault   = state_q.wr_fault;
    assign wr_gp      = state_q.wr_gp;
    assign rd_valid   = state_q.rd_valid;
    assign rd_fault   = state_q.rd_fault;
    assign rd_data    = state_q.rd_data;
    assign var_base_o = state_q.vbase;
    assign var_mask_o = state_q.vmask;
    assign fixed_o    = state_q.fixed;
    assign glob_en_o  = state_q.deftype[11];
    assign fix_en_o   = state_q.deftype[10];
    assign def_type_o = state_q.deftype[7:0];

    for (genvar i = 0; i < NUM_VAR; i++) begin : g_valid
        assign var_valid_o[i] = state_q.vmask[i][11];

        // R6: a mask that has been accepted carries ones above the address width
        p_mask_high_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
            state_q.vmask[i][11] |-> (&state_q.vmask[i][63:PA_W]));
    end

    logic [STORE_W-1:0] store_view;
    assign store_view = {state_q.vbase, state_q.vmask, state_q.fixed,
                         state_q.deftype, state_q.pat};

    logic past_live;
    always_ff @(posedge clk) begin
        if (!rst_n) past_live <= 1'b0;
        else        past_live <= 1'b1;
    end

    // R2: every write gets exactly one acknowledge in the following cycle
    p_ack_follows_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_live |-> (wr_ack == $past(wr_en)));

    // R2: the protection indication never appears without a refusal
    p_gp_needs_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gp |-> (wr_fault && wr_ack));

    // R3: a refused write leaves the stored registers untouched
    p_reject_keeps_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ok) |=> $stable(store_view));

    // R11: every read is answered one cycle later
    p_rd_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        past_live |-> (rd_valid == $past(rd_en)));

    // R11: an unknown read number returns zero data
    p_rd_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault |-> (rd_valid && rd_data == 64'd0));

endmodule

// File: tb/memtype_range_regs_tb.sv
module memtype_range_regs_tb;
    localparam int unsigned NV = 8;
    localparam int unsigned PW = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_num = '0;
    logic [63:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_num = '0;
    logic        wr_ack, wr_fault, wr_gp, rd_valid, rd_fault;
    logic [63:0] rd_data;
    logic [64*NV-1:0] var_base_o, var_mask_o;
    logic [NV-1:0]    var_valid_o;
    logic [64*11-1:0] fixed_o;
    logic             glob_en_o, fix_en_o;
    logic [7:0]       def_type_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    memtype_range_regs #(.NUM_VAR(NV), .PA_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
        .rd_en(rd_en), .rd_num(rd_num), .wr_ack(wr_ack), .wr_fault(wr_fault),
        .wr_gp(wr_gp), .rd_valid(rd_valid), .rd_fault(rd_fault), .rd_data(rd_data),
        .var_base_o(var_base_o), .var_mask_o(var_mask_o), .var_valid_o(var_valid_o),
        .fixed_o(fixed_o), .glob_en_o(glob_en_o), .fix_en_o(fix_en_o),
        .def_type_o(def_type_o)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a write at a falling edge; results are sampled one clock later.
    task automatic do_wr(logic [31:0] n, logic [63:0] d, output logic f, output logic g);
        @(negedge clk);
        wr_en = 1'b1; wr_num = n; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2 ack", {63'd0, wr_ack}, 64'd1);
        f = wr_fault;
        g = wr_gp;
        @(negedge clk);
        chk("R2 ack single", {63'd0, wr_ack}, 64'd0);
    endtask

    task automatic do_rd(logic [31:0] n, output logic [63:0] d, output logic f);
        @(negedge clk);
        rd_en = 1'b1; rd_num = n;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R11 rd_valid", {63'd0, rd_valid}, 64'd1);
        d = rd_data;
        f = rd_fault;
    endtask

    task automatic wr_expect(string req, logic [31:0] n, logic [63:0] d, logic ef, logic eg);
        logic f, g;
        do_wr(n, d, f, g);
        chk({req, " fault"}, {63'd0, f}, {63'd0, ef});
        chk({req, " gp"}, {63'd0, g}, {63'd0, eg});
    endtask

    task automatic rd_expect(string req, logic [31:0] n, logic [63:0] ed, logic ef);
        logic [63:0] d;
        logic f;
        do_rd(n, d, f);
        chk({req, " data"}, d, ed);
        chk({req, " rd_fault"}, {63'd0, f}, {63'd0, ef});
    endtask

    task automatic t_reset;
        chk("R1 wr_ack", {63'd0, wr_ack}, 64'd0);
        chk("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
        chk("R1 valid", {56'd0, var_valid_o}, 64'd0);
        chk("R1 deftype", {53'd0, glob_en_o, fix_en_o, 1'b0, def_type_o}, 64'd0);
        rd_expect("R1 base0", 32'h200, 64'd0, 1'b0);
        rd_expect("R1 pat", 32'h277, 64'd0, 1'b0);
    endtask

    task automatic t_var_base;
        wr_expect("R4 legal base", 32'h202, 64'h0000_0001_2340_0006, 1'b0, 1'b0);
        chk("R4 base port", var_base_o[64 +: 64], 64'h0000_0001_2340_0006);
        wr_expect("R4 bit9 rsvd", 32'h202, 64'h0000_0001_2340_0206, 1'b1, 1'b1);
        wr_expect("R4 type2", 32'h202, 64'h0000_0000_1000_0002, 1'b1, 1'b0);
        wr_expect("R4 above width", 32'h202, 64'h0000_0010_0000_0006, 1'b1, 1'b1);
        rd_expect("R4 base kept", 32'h202, 64'h0000_0001_2340_0006, 1'b0);
        rd_expect("R4 neighbour", 32'h200, 64'd0, 1'b0);
    endtask

    task automatic t_var_mask;
        wr_expect("R5 legal mask", 32'h203, 64'h0000_000F_FFF0_0800, 1'b0, 1'b0);
        chk("R6 mask ext", var_mask_o[64 +: 64], 64'hFFFF_FFFF_FFF0_0800);
        chk("R7 valid1", {56'd0, var_valid_o}, 64'h02);
        rd_expect("R6 mask clip", 32'h203, 64'h0000_000F_FFF0_0800, 1'b0);
        wr_expect("R5 low rsvd", 32'h203, 64'h0000_000F_FFF0_0820, 1'b1, 1'b1);
        wr_expect("R5 high rsvd", 32'h203, 64'h0000_0100_0000_0800, 1'b1, 1'b1);
        rd_expect("R5 mask kept", 32'h203, 64'h0000_000F_FFF0_0800, 1'b0);
        wr_expect("R7 no valid", 32'h20F, 64'h0000_000F_0000_0000, 1'b0, 1'b0);
        chk("R7 valid7 off", {56'd0, var_valid_o}, 64'h02);
        chk("R6 mask7 ext", var_mask_o[7*64 +: 64], 64'hFFFF_FFFF_0000_0000);
        rd_expect("R6 mask7 clip", 32'h20F, 64'h0000_000F_0000_0000, 1'b0);
    endtask

    task automatic t_fixed;
        wr_expect("R8 4k legal", 32'h268, 64'h0605_0401_0001_0506, 1'b0, 1'b0);
        chk("R8 4k slot", fixed_o[3*64 +: 64], 64'h0605_0401_0001_0506);
        wr_expect("R8 16k legal", 32'h259, 64'h0101_0101_0101_0101, 1'b0, 1'b0);
        chk("R8 16k slot", fixed_o[2*64 +: 64], 64'h0101_0101_0101_0101);
        wr_expect("R8 byte3 type7", 32'h268, 64'h0605_0401_0701_0506, 1'b1, 1'b0);
        wr_expect("R8 byte high", 32'h26F, 64'h1000_0000_0000_0000, 1'b1, 1'b0);
        rd_expect("R8 4k kept", 32'h268, 64'h0605_0401_0001_0506, 1'b0);
        rd_expect("R8 64k zero", 32'h250, 64'd0, 1'b0);
    endtask

    task automatic t_deftype;
        wr_expect("R9 legal", 32'h2FF, 64'h0000_0000_0000_0C06, 1'b0, 1'b0);
        chk("R9 fields", {53'd0, glob_en_o, fix_en_o, 1'b0, def_type_o}, 64'h0000_0000_0000_0606);
        wr_expect("R9 bit12", 32'h2FF, 64'h0000_0000_0000_1C06, 1'b1, 1'b0);
        wr_expect("R9 bit8", 32'h2FF, 64'h0000_0000_0000_0906, 1'b1, 1'b0);
        wr_expect("R9 type2", 32'h2FF, 64'h0000_0000_0000_0C02, 1'b1, 1'b0);
        rd_expect("R9 kept", 32'h2FF, 64'h0000_0000_0000_0C06, 1'b0);
        wr_expect("R9 en only", 32'h2FF, 64'h0000_0000_0000_0800, 1'b0, 1'b0);
        chk("R9 fields2", {53'd0, glob_en_o, fix_en_o, 1'b0, def_type_o}, 64'h0000_0000_0000_0400);
    endtask

    task automatic t_pat;
        wr_expect("R10 legal", 32'h277, 64'h0706_0504_0100_0706, 1'b0, 1'b0);
        wr_expect("R10 type2", 32'h277, 64'h0706_0504_0100_0702, 1'b1, 1'b0);
        wr_expect("R10 type3", 32'h277, 64'h0306_0504_0100_0706, 1'b1, 1'b0);
        rd_expect("R10 kept", 32'h277, 64'h0706_0504_0100_0706, 1'b0);
    endtask

    task automatic t_unknown;
        wr_expect("R3 past ranges", 32'h210, 64'h0000_0000_0000_0006, 1'b1, 1'b0);
        wr_expect("R3 cap write", 32'h0FE, 64'h0000_0000_0000_0000, 1'b1, 1'b0);
        rd_expect("R11 unknown", 32'h210, 64'd0, 1'b1);
        rd_expect("R11 cap", 32'h0FE, 64'h0000_0000_0000_0508, 1'b0);
        chk("R3 valid kept", {56'd0, var_valid_o}, 64'h02);
    endtask

    task automatic t_collision;
        logic [63:0] d;
        @(negedge clk);
        wr_en = 1'b1; wr_num = 32'h202; wr_data = 64'h0000_0000_0000_0005;
        rd_en = 1'b1; rd_num = 32'h202;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R11 old on collide", rd_data, 64'h0000_0001_2340_0006);
        chk("R2 collide accept", {63'd0, wr_fault}, 64'd0);
        do_rd(32'h202, d, rd_fault_dummy);
        chk("R11 new after", d, 64'h0000_0000_0000_0005);
    endtask
    logic rd_fault_dummy;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_var_base();
        t_var_mask();
        t_fixed();
        t_deftype();
        t_pat();
        t_unknown();
        t_collision();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule